// File: doc/BRIEF.md
# External Count Event Qualifier

This block sits in front of a timer counter and decides, on every cycle of a fast internal clock, whether the counter should advance. With the internal source selected, it asks for a count on every enabled cycle. With the external source selected, an asynchronous input pin goes through a synchronizer and then a glitch filter with a selectable stability length. An active-edge selector then turns qualified transitions into single-cycle count-enable pulses.

Configuration is a 5-bit word written through a write strobe. It is accepted only while the block is disabled and only when it does not carry the reserved polarity code. A rejected write leaves the stored word untouched and raises a one-cycle error flag. The stored word can be read back at all times. While the block is disabled, the filter's accepted level follows the synchronized input, so switching the block on never produces a spurious count.

Top module: `cnt_event_qual`

## Requirements
- R1: After reset, `cnt_pulse` is 0, `cfg_q` is 0 and `cfg_err` is 0.
- R2: The configuration word holds the source select in bit 0 (0 = internal, 1 = external), the polarity code in bits 2:1 and the filter code in bits 4:3. A write with `en`=0 and a polarity code other than 11 appears on `cfg_q` one clock after the strobe.
- R3: A write strobed while `en`=1 leaves `cfg_q` unchanged, and `cfg_err` is 1 for exactly the one clock that follows the strobe.
- R4: A write whose polarity code is 11 is dropped as a whole, even while disabled, and `cfg_err` pulses for one clock.
- R5: The external input passes through a two-stage synchronizer. With filter code 00, a level change held on `ext_in` gives its pulse on the third rising clock edge after the change, lasting one clock.
- R6: Filter codes 00, 01, 10 and 11 require 1, 2, 4 and 8 consecutive equal synchronized samples, respectively, before a level change is accepted. A shorter excursion produces no pulse.
- R7: Polarity 00 counts only rising accepted transitions, and polarity 01 counts only falling ones.
- R8: Polarity 10 counts both rising and falling accepted transitions, giving one pulse for each.
- R9: With `en`=1 and source select 0, `cnt_pulse` is 1 on every clock.
- R10: With `en`=0, `cnt_pulse` stays 0 whatever the input and configuration.
- R11: Enabling the block while `ext_in` sits at a level that differs from the level seen before produces no pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Internal sampling and filtering clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| en | input | 1 | Block enable; configuration is locked while 1 |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 5 | Configuration word to write |
| cfg_q | output | 5 | Stored configuration word |
| cfg_err | output | 1 | One-clock flag for a rejected write |
| ext_in | input | 1 | Raw asynchronous external count input |
| cnt_pulse | output | 1 | Count-enable pulse to the timer counter |

## Verification
The embedded properties check the following on every clock:
- the configuration never changes in a cycle that follows an enabled cycle;
- the reserved polarity code never reaches storage;
- each error flag follows a write strobe;
- accepted-edge strobes are mutually exclusive and match the accepted level;
- enabling the block never produces an external pulse in its first cycle.

Filter lengths, the exact three-edge latency, the count of pulses for each polarity, and the dropping of short glitches depend on input histories. Only the bench's scenarios can show these, through its vector table of pulse widths against filter and polarity codes.

// File: rtl/cq_pkg.sv
package cq_pkg;

   typedef enum logic [1:0] {
      POL_RISE = 2'b00,
      POL_FALL = 2'b01,
      POL_BOTH = 2'b10,
      POL_RSVD = 2'b11
   } pol_e;

   // bits 4:3 filter code, bits 2:1 polarity, bit 0 source select
   typedef struct packed {
      logic [1:0] filt;
      pol_e       pol;
      logic       src_ext;
   } cfg_t;

   localparam int CFG_W  = $bits(cfg_t);
   localparam int FILT_CODE_W = 2;

endpackage

// File: rtl/cq_cfg.sv
module cq_cfg
   import cq_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             we,
   input  logic [CFG_W-1:0] wdata,
   output cfg_t             cfg,
   output logic             err
);

   cfg_t wcfg;
   logic reject;

   assign wcfg   = cfg_t'(wdata);
   assign reject = en || (wcfg.pol == POL_RSVD);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg <= '0;
         err <= 1'b0;
      end else begin
         err <= 1'b0;
         if (we) begin
            if (reject) err <= 1'b1;
            else        cfg <= wcfg;
         end
      end
   end

   AST_CFG_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      en |=> $stable(cfg)); // R3

   AST_NO_RSVD_POL: assert property (@(posedge clk) disable iff (!rst_n)
      cfg.pol != POL_RSVD); // R4

   AST_ERR_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> $past(we)); // R3

endmodule

// File: rtl/cq_sync.sv
module cq_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("cq_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[0] <= 1'b0;
      else        chain[0] <= d;
   end

   for (genvar i = 1; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain[i] <= 1'b0;
         else        chain[i] <= chain[i-1];
      end
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/cq_filter.sv
module cq_filter
   import cq_pkg::*;
#(
   parameter int MAX_LEN = 8
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   en,
   input  logic [FILT_CODE_W-1:0] code,
   input  logic                   din,
   output logic                   level,
   output logic                   rise_stb,
   output logic                   fall_stb
);

   localparam int CNT_W = $clog2(MAX_LEN);

   generate
      if (MAX_LEN < (1 << ((1 << FILT_CODE_W) - 1))) begin : g_bad_len
         $error("cq_filter: MAX_LEN too small for the largest filter code");
      end
   endgenerate

   logic [CNT_W-1:0] run_cnt;
   logic [CNT_W-1:0] limit;

   assign limit = CNT_W'((1 << code) - 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         level    <= 1'b0;
         run_cnt  <= '0;
         rise_stb <= 1'b0;
         fall_stb <= 1'b0;
      end else begin
         rise_stb <= 1'b0;
         fall_stb <= 1'b0;
         if (!en) begin
            level   <= din;
            run_cnt <= '0;
         end else if (din == level) begin
            run_cnt <= '0;
         end else if (run_cnt == limit) begin
            level    <= din;
            run_cnt  <= '0;
            rise_stb <= din;
            fall_stb <= ~din;
         end else begin
            run_cnt <= run_cnt + 1'b1;
         end
      end
   end

   AST_STB_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({rise_stb, fall_stb})); // R8

   AST_RISE_MATCHES: assert property (@(posedge clk) disable iff (!rst_n)
      rise_stb |-> (level && !$past(level) && $past(en))); // R7

   AST_FALL_MATCHES: assert property (@(posedge clk) disable iff (!rst_n)
      fall_stb |-> (!level && $past(level) && $past(en))); // R7

endmodule

// File: rtl/cq_edge.sv
module cq_edge
   import cq_pkg::*;
(
   input  pol_e pol,
   input  logic rise_stb,
   input  logic fall_stb,
   output logic pulse
);

   always_comb begin
      unique case (pol)
         POL_RISE: pulse = rise_stb;
         POL_FALL: pulse = fall_stb;
         POL_BOTH: pulse = rise_stb | fall_stb;
         default:  pulse = 1'b0;
      endcase
   end

endmodule

// File: rtl/cnt_event_qual.sv
module cnt_event_qual
   import cq_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int MAX_FILT    = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             cfg_we,
   input  logic [CFG_W-1:0] cfg_wdata,
   output logic [CFG_W-1:0] cfg_q,
   output logic             cfg_err,
   input  logic             ext_in,
   output logic             cnt_pulse
);

   cfg_t cfg;
   logic sync_in;
   logic level;
   logic rise_stb;
   logic fall_stb;
   logic ext_pulse;

   cq_cfg u_cfg (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (en),
      .we    (cfg_we),
      .wdata (cfg_wdata),
      .cfg   (cfg),
      .err   (cfg_err)
   );

   cq_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (ext_in),
      .q     (sync_in)
   );

   cq_filter #(.MAX_LEN(MAX_FILT)) u_filt (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (en),
      .code     (cfg.filt),
      .din      (sync_in),
      .level    (level),
      .rise_stb (rise_stb),
      .fall_stb (fall_stb)
   );

   cq_edge u_edge (
      .pol      (cfg.pol),
      .rise_stb (rise_stb),
      .fall_stb (fall_stb),
      .pulse    (ext_pulse)
   );

   assign cfg_q     = cfg;
   assign cnt_pulse = en & (cfg.src_ext ? ext_pulse : 1'b1);

   AST_NO_FALSE_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(en) |-> !ext_pulse); // R11

   AST_LEVEL_TRACKS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!en) |-> (level == $past(sync_in))); // R11

endmodule

// File: tb/sim_cnt_event_qual.sv
module sim_cnt_event_qual;

   localparam int CLK_PERIOD = 10;
   localparam int NVEC = 10;

   // {filter code, polarity code, high width in clocks, expected pulses}
   localparam logic [15:0] VEC [NVEC] = '{
      {2'd0, 2'd0, 8'd1, 4'd1},
      {2'd1, 2'd0, 8'd1, 4'd0},
      {2'd1, 2'd0, 8'd2, 4'd1},
      {2'd2, 2'd1, 8'd3, 4'd0},
      {2'd2, 2'd1, 8'd4, 4'd1},
      {2'd3, 2'd2, 8'd7, 4'd0},
      {2'd3, 2'd2, 8'd8, 4'd2},
      {2'd0, 2'd2, 8'd1, 4'd2},
      {2'd3, 2'd1, 8'd9, 4'd1},
      {2'd1, 2'd2, 8'd3, 4'd2}
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       en = 1'b0;
   logic       cfg_we = 1'b0;
   logic [4:0] cfg_wdata = '0;
   logic [4:0] cfg_q;
   logic       cfg_err;
   logic       ext_in = 1'b0;
   logic       cnt_pulse;

   int total = 0;
   int bad = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   cnt_event_qual u0 (
      .clk(clk), .rst_n(rst_n), .en(en), .cfg_we(cfg_we),
      .cfg_wdata(cfg_wdata), .cfg_q(cfg_q), .cfg_err(cfg_err),
      .ext_in(ext_in), .cnt_pulse(cnt_pulse)
   );

   task automatic check(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic write_cfg(input logic [4:0] w);
      @(negedge clk);
      cfg_we = 1'b1;
      cfg_wdata = w;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic count_pulses(input int cycles, output int n);
      n = 0;
      for (int i = 0; i < cycles; i++) begin
         @(negedge clk);
         if (cnt_pulse) n++;
      end
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      total++;
      bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      int n;
      logic [4:0] w;
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1 cnt_pulse", cnt_pulse, 0);
      check("R1 cfg_q", cfg_q, 0);
      check("R1 cfg_err", cfg_err, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // vector table walk: R6 R7 R8
      for (int v = 0; v < NVEC; v++) begin
         en = 1'b0;
         w = {VEC[v][15:14], VEC[v][13:12], 1'b1};
         write_cfg(w);
         check("R2 cfg_q after write", cfg_q, w);
         en = 1'b1;
         repeat (3) @(negedge clk);
         ext_in = 1'b1;
         count_pulses(int'(VEC[v][11:4]), n);
         ext_in = 1'b0;
         begin
            int m;
            count_pulses(24, m);
            n += m;
         end
         check("R6/R7/R8 pulse count", n, int'(VEC[v][3:0]));
      end

      // R5 exact latency with filter 00, rising polarity
      en = 1'b0;
      write_cfg(5'b00_00_1);
      en = 1'b1;
      repeat (3) @(negedge clk);
      ext_in = 1'b1;
      @(negedge clk); check("R5 after edge 1", cnt_pulse, 0);
      @(negedge clk); check("R5 after edge 2", cnt_pulse, 0);
      @(negedge clk); check("R5 after edge 3", cnt_pulse, 1);
      @(negedge clk); check("R5 after edge 4", cnt_pulse, 0);

      // R3 write while enabled is ignored and flagged
      @(negedge clk);
      cfg_we = 1'b1;
      cfg_wdata = 5'b11_10_0;
      @(negedge clk);
      cfg_we = 1'b0;
      check("R3 cfg_err high", cfg_err, 1);
      check("R3 cfg_q unchanged", cfg_q, 5'b00_00_1);
      @(negedge clk);
      check("R3 cfg_err one cycle", cfg_err, 0);

      // R4 reserved polarity rejected while disabled
      en = 1'b0;
      ext_in = 1'b0;
      @(negedge clk);
      cfg_we = 1'b1;
      cfg_wdata = 5'b10_11_1;
      @(negedge clk);
      cfg_we = 1'b0;
      check("R4 cfg_err high", cfg_err, 1);
      check("R4 cfg_q unchanged", cfg_q, 5'b00_00_1);

      // R11 no false edge on enable after input moved while disabled
      repeat (4) @(negedge clk);
      ext_in = 1'b1;
      repeat (6) @(negedge clk);
      en = 1'b1;
      count_pulses(15, n);
      check("R11 no pulse on enable", n, 0);

      // R10 disabled gives no pulses, even with internal source
      en = 1'b0;
      write_cfg(5'b00_10_0);
      ext_in = 1'b0;
      count_pulses(10, n);
      check("R10 disabled quiet", n, 0);

      // R9 internal source counts every clock
      en = 1'b1;
      count_pulses(10, n);
      check("R9 internal every cycle", n, 10);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule